// File: doc/BRIEF.md
# Direct Sum-to-Booth Digit Recoder

This block takes two signed two's-complement operands of equal width and emits the radix-4 modified Booth digits of their sum. No carry-propagating adder sits between the operands and the digits. Each digit slice takes two bit pairs, one from each operand, and two carries from the slice below. It builds three recoding bits from a conventional full adder, a conventional half adder and a half adder whose sum output carries negative weight. The middle bit of the resulting digit can then only take the values 0 or −1 times two, so every digit lands in {−2, −1, 0, +1, +2}. A multiplier that follows can use these digits as the Booth-encoded multiplier of a fused add-multiply datapath.

Both operands are sign-extended to an even width of 2K bits, where K = ceil((N+1)/2). Odd widths get one extra bit and even widths get two. As a result, the top slice always sees two equal sign bits per operand, and the carries out of the top slice can be dropped without error. The digits are captured in an output register when `inValid` is high. `outValid` marks a freshly captured set.

Top module: `sum_booth_recoder`

## Requirements
- R1: For operand width N = 7, for every pair of operands, the weighted digit sum Σ y(j)·4^j equals A+B.
- R2: For operand width N = 6, for every pair of operands, the weighted digit sum Σ y(j)·4^j equals A+B.
- R3: Digit j has the value y(j) = (digNeg[j] ? −1 : +1) · (digOne[j] + 2·digTwo[j]), so it always lies in −2..+2. digOne[j] and digTwo[j] are never both 1.
- R4: A zero digit is encoded as all three bits 0, so digNeg[j] is never 1 while digOne[j] and digTwo[j] are both 0. A zero sum (0+0, or 1 + −1) yields all-zero digit vectors.
- R5: Operands presented with inValid high appear on the digit outputs after the next rising clock edge and not before it. outValid is 1 in exactly the cycle after a cycle with inValid high.
- R6: While inValid is low, a clock edge leaves the digit outputs unchanged whatever the operands do, and outValid reads 0.
- R7: While rstN is low, outValid and every digit bit are 0.
- R8: The extremes are represented exactly. Both operands at the most negative value give −2^N, and both at the most positive value give 2^N − 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Capture strobe for the operands |
| opA | input | N | First signed operand |
| opB | input | N | Second signed operand |
| outValid | output | 1 | Digits were captured in the previous cycle |
| digNeg | output | K | Per-digit negate flag |
| digOne | output | K | Per-digit magnitude-one flag |
| digTwo | output | K | Per-digit magnitude-two flag |

## Verification
Every digit result and outValid are due exactly one rising edge after the operands are presented with inValid high. The bench drives at the falling edge and reads at the following falling edge, one full cycle later. For the latency check it also reads once just after driving, before the rising edge, to confirm that the old digits are still present. Hold behaviour is read one cycle after operands change with inValid low. The expected value in every case is the integer sum A+B, compared against the digits decoded with the R3 weighting.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;

  // One radix-4 digit: sign plus one-hot magnitude
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } boothDigit_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  // Map the recoding bits (hi weight -2, lo weight +1, carry weight +1)
  // onto sign/magnitude form.
  function automatic boothDigit_t encodeDigit(input logic sHi,
                                              input logic sLo,
                                              input logic cIn);
    boothDigit_t d;
    d.one = sLo ^ cIn;
    d.two = (sHi & ~sLo & ~cIn) | (~sHi & sLo & cIn);
    d.neg = sHi & ~(sLo & cIn);
    return d;
  endfunction

endpackage

// File: rtl/sbr_cell.sv
`timescale 1ns/1ps
module sbr_cell
  import sbr_pkg::*;
(
  input  logic        aLo,
  input  logic        bLo,
  input  logic        aHi,
  input  logic        bHi,
  input  logic        cinHa,
  input  logic        cinNeg,
  output logic        coutHa,
  output logic        coutNeg,
  output boothDigit_t dig
);

  logic sLo;
  logic cMid;
  logic hHi;
  logic sHi;

  // conventional full adder on the low bit pair plus carry from below
  assign sLo  = aLo ^ bLo ^ cinHa;
  assign cMid = (aLo & bLo) | (cinHa & (aLo ^ bLo));

  // conventional half adder on the high bit pair; carry goes upward
  assign hHi    = aHi ^ bHi;
  assign coutHa = aHi & bHi;

  // half adder with negatively weighted sum: hHi + cMid = 2*coutNeg - sHi
  assign sHi     = hHi ^ cMid;
  assign coutNeg = hHi | cMid;

  assign dig = encodeDigit(sHi, sLo, cinNeg);

endmodule

// File: rtl/sbr_datapath.sv
`timescale 1ns/1ps
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int N = 7,
  parameter int K = (N + 2) / 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [K-1:0] negQ,
  output logic [K-1:0] oneQ,
  output logic [K-1:0] twoQ
);

  localparam int W   = 2 * K;
  localparam int EXT = W - N;

  logic [W-1:0] aExt;
  logic [W-1:0] bExt;
  assign aExt = {{EXT{opA[N-1]}}, opA};
  assign bExt = {{EXT{opB[N-1]}}, opB};

  logic [K-1:0] cHa;
  logic [K-1:0] cNeg;
  boothDigit_t [K-1:0] digC;

  assign cHa[0]  = 1'b0;
  assign cNeg[0] = 1'b0;

  for (genvar j = 0; j < K; j++) begin : g_digit
    if (j < K - 1) begin : g_mid
      sbr_cell u_cell (
        .aLo    (aExt[2*j]),
        .bLo    (bExt[2*j]),
        .aHi    (aExt[2*j+1]),
        .bHi    (bExt[2*j+1]),
        .cinHa  (cHa[j]),
        .cinNeg (cNeg[j]),
        .coutHa (cHa[j+1]),
        .coutNeg(cNeg[j+1]),
        .dig    (digC[j])
      );
    end else begin : g_top
      // Top slice: both bit pairs are sign copies, so carries out are
      // exactly cancelled by the sign weight and are not formed.
      logic sLo;
      logic cMid;
      logic sHi;
      assign sLo  = aExt[2*j] ^ bExt[2*j] ^ cHa[j];
      assign cMid = (aExt[2*j] & bExt[2*j]) | (cHa[j] & (aExt[2*j] ^ bExt[2*j]));
      assign sHi  = aExt[2*j+1] ^ bExt[2*j+1] ^ cMid;
      assign digC[j] = encodeDigit(sHi, sLo, cNeg[j]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      negQ <= '0;
      oneQ <= '0;
      twoQ <= '0;
    end else if (strobe.load) begin
      for (int j = 0; j < K; j++) begin
        negQ[j] <= digC[j].neg;
        oneQ[j] <= digC[j].one;
        twoQ[j] <= digC[j].two;
      end
    end
  end

endmodule

// File: rtl/sbr_control.sv
`timescale 1ns/1ps
module sbr_control
  import sbr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe      = '0;
    strobe.load = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/sum_booth_recoder.sv
`timescale 1ns/1ps
module sum_booth_recoder
  import sbr_pkg::*;
#(
  parameter int N = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [N-1:0]            opA,
  input  logic [N-1:0]            opB,
  output logic                    outValid,
  output logic [((N+2)/2)-1:0]    digNeg,
  output logic [((N+2)/2)-1:0]    digOne,
  output logic [((N+2)/2)-1:0]    digTwo
);

  localparam int K = (N + 2) / 2;

  ctrlStrobe_t strobe;

  sbr_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  sbr_datapath #(.N(N), .K(K)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .negQ  (digNeg),
    .oneQ  (digOne),
    .twoQ  (digTwo)
  );

endmodule

// File: rtl/sbr_checker.sv
`timescale 1ns/1ps
module sbr_checker #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         outValid,
  input logic [K-1:0] digNeg,
  input logic [K-1:0] digOne,
  input logic [K-1:0] digTwo
);

  p_mag_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((digOne & digTwo) == '0));

  p_no_neg_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((digNeg & ~(digOne | digTwo)) == '0));

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(digNeg) && $stable(digOne) && $stable(digTwo)));

endmodule

bind sum_booth_recoder sbr_checker #(.K(K)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .digNeg  (digNeg),
  .digOne  (digOne),
  .digTwo  (digTwo)
);

// File: tb/tb_sum_booth_recoder.sv
`timescale 1ns/1ps
module tb_sum_booth_recoder;

  localparam int NO = 7;
  localparam int NE = 6;
  localparam int KO = (NO + 2) / 2;
  localparam int KE = (NE + 2) / 2;
  localparam int NVEC = 8;
  // directed table for the odd width: {A, B, expected sum}
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 0}, '{-64, -64, -128}, '{63, 63, 126}, '{-64, 63, -1},
    '{1, -1, 0}, '{21, 21, 42}, '{-43, -22, -65}, '{42, -21, 21}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [NO-1:0] opAO = '0, opBO = '0;
  logic [NE-1:0] opAE = '0, opBE = '0;
  logic outValidO, outValidE;
  logic [KO-1:0] negO, oneO, twoO;
  logic [KE-1:0] negE, oneE, twoE;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sum_booth_recoder #(.N(NO)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opAO), .opB(opBO),
    .outValid(outValidO), .digNeg(negO), .digOne(oneO), .digTwo(twoO)
  );

  sum_booth_recoder #(.N(NE)) dutEven (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opAE), .opB(opBE),
    .outValid(outValidE), .digNeg(negE), .digOne(oneE), .digTwo(twoE)
  );

  function automatic int decodeO();
    int v = 0;
    int w = 1;
    for (int j = 0; j < KO; j++) begin
      int d = oneO[j] ? 1 : (twoO[j] ? 2 : 0);
      if (negO[j]) d = -d;
      v += d * w;
      w *= 4;
    end
    return v;
  endfunction

  function automatic int decodeE();
    int v = 0;
    int w = 1;
    for (int j = 0; j < KE; j++) begin
      int d = oneE[j] ? 1 : (twoE[j] ? 2 : 0);
      if (negE[j]) d = -d;
      v += d * w;
      w *= 4;
    end
    return v;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // R3/R4 encoding legality as a count of illegal digits
  function automatic int badCodes();
    return $countones(oneO & twoO) + $countones(negO & ~(oneO | twoO))
         + $countones(oneE & twoE) + $countones(negE & ~(oneE | twoE));
  endfunction

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7 outValid", int'(outValidO) + int'(outValidE), 0);
    check("R7 digits", int'({negO, oneO, twoO}) + int'({negE, oneE, twoE}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R8: directed table, odd width
    foreach (VEC[i]) begin
      opAO = VEC[i][0][NO-1:0];
      opBO = VEC[i][1][NO-1:0];
      inValid = 1'b1;
      @(negedge clk);
      if (i == 1 || i == 2) check("R8 extreme", decodeO(), VEC[i][2]);
      else                  check("R1 table", decodeO(), VEC[i][2]);
      check("R3 code", badCodes(), 0);
    end

    // R4: zero sums give all-zero bits
    opAO = 7'd1; opBO = '1; opAE = '0; opBE = '0;
    @(negedge clk);
    check("R4 zero odd", int'({negO, oneO, twoO}), 0);
    check("R4 zero even", int'({negE, oneE, twoE}), 0);

    // R5: latency and valid
    opAO = 7'd5; opBO = 7'd9;
    @(negedge clk);
    check("R5 valid", int'(outValidO), 1);
    opAO = 7'd30; opBO = 7'd3;
    #1;
    check("R5 before edge", decodeO(), 14);
    @(negedge clk);
    check("R5 after edge", decodeO(), 33);

    // R6: hold while idle
    inValid = 1'b0;
    opAO = 7'd50; opBO = 7'd7; opAE = 6'd20; opBE = 6'd11;
    @(negedge clk);
    check("R6 hold odd", decodeO(), 33);
    check("R6 hold even", decodeE(), 0);
    check("R6 outValid", int'(outValidO), 0);
    @(negedge clk);
    check("R6 hold later", decodeO(), 33);

    // R1: exhaustive odd width
    inValid = 1'b1;
    for (int a = -64; a < 64; a++) begin
      for (int b = -64; b < 64; b++) begin
        opAO = a[NO-1:0];
        opBO = b[NO-1:0];
        @(negedge clk);
        check("R1 exhaustive", decodeO(), a + b);
        check("R3 code", badCodes(), 0);
      end
    end

    // R2/R8: exhaustive even width
    for (int a = -32; a < 32; a++) begin
      for (int b = -32; b < 32; b++) begin
        opAE = a[NE-1:0];
        opBE = b[NE-1:0];
        @(negedge clk);
        if (a == -32 && b == -32) check("R8 even min", decodeE(), -64);
        check("R2 exhaustive", decodeE(), a + b);
      end
    end

    finished = 1'b1;
    finish();
  end

endmodule